// File: doc/BRIEF.md
# Logic Self-Test Session Sequencer

This block runs one complete logic self-test session over a set of scan chains that span several clock domains. Software writes a small bank of configuration registers: the generator seed, the pattern count, the shift length, a table of capture steps with a depth limit, the expected signature and a set of static test-mode constraint bits. It then pulses `start`. The sequencer loads the seed into a 32-bit Galois pattern generator and shifts generated stimulus into every chain. It applies the programmed capture steps, which pulse selected clock domains one step per cycle. It compacts the scan-out stream into a 32-bit signature register while the following pattern is being loaded.

After the programmed number of patterns, one unload-only pass empties the chains. The signature is then compared with the expected value, and `done` and `pass` are held until the next `start`. Scan-out bits flagged by the X-mask input enter the signature as zero, so unknown sources cannot disturb the result. The constraint bits drive the design under test unchanged for the whole session.

Top module: `lbist_ctrl`

## Requirements
- R1: After reset, `done`, `pass`, `scan_en` and every `dom_clk_en` bit are 0, and `case_ctl` is 0.
- R2: At session start the generator takes the seed from register 0, or 32'hC0DE5EED when that seed is zero. Each load-shift cycle, `scan_in[c]` equals generator bit c. The generator then advances as state>>1, XORed with 32'h80200003 when the bit shifted out was 1.
- R3: Each pass holds `scan_en` high for exactly the shift length from register 2 (bits 15:0), with 0 treated as 1.
- R4: A session makes P load passes followed by one unload-only pass, where P comes from register 1 (bits 15:0) with 0 treated as 1. `scan_en` is therefore high for (P+1) times the shift length cycles.
- R5: After each load pass, capture steps run one per cycle in index order. Step i's domain mask sits in byte i of registers 4 (steps 0-3) and 5 (steps 4-7), with bit d selecting domain d. `dom_clk_en` equals that mask. The sequence ends after the depth from register 3 (bits 3:0, 0 treated as 1, at most 8), or before the first zero mask.
- R6: `scan_en` is high only during shift cycles, and during those cycles every `dom_clk_en` bit is 1. Outside shift and capture, `dom_clk_en` is 0.
- R7: The signature starts at zero. In every shift cycle of the second and later passes, it becomes the generator step of its old value XORed with the masked scan-out word placed in its low bits. The first pass does not change it.
- R8: Any scan-out bit whose `xmask` bit is 1 enters the signature as 0, whatever its value.
- R9: At session end `done` rises, and `pass` equals 1 exactly when the signature equals register 6. Both hold, with the signature frozen, until the next `start`.
- R10: `case_ctl` drives the value of register 7 (low bits). Configuration writes made while a session is running are ignored. Writes made while idle or done take effect.
- R11: During the unload-only pass `scan_in` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| start | input | 1 | Begins a session when idle or done |
| done | output | 1 | Session finished, held until next start |
| pass | output | 1 | Signature matched expected value |
| dom_clk_en | output | NDOM | Per-domain clock enable |
| scan_en | output | 1 | Scan shift enable |
| scan_in | output | NCH | Stimulus into each scan chain |
| scan_out | input | NCH | Response from each scan chain |
| xmask | input | NCH | Marks scan-out bits as unknown |
| case_ctl | output | CASE_W | Static test-mode constraint outputs |

## Verification
The generator load of the next pattern and the compaction of the previous pattern's response happen in the very same shift cycles. A fault in either one shows only in the final signature. The bench therefore models the scan chains itself: it feeds the chains from `scan_in`, applies a capture transform per domain and returns `scan_out` with random junk on X-masked bits. It recomputes the whole session in software, with its own generator and compactor, and judges `pass` against a correct and a deliberately corrupted expected signature. A configuration write is also issued mid-session, in the same cycles as shifting and capture, and `case_ctl` and the signature outcome show that it was ignored.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

  localparam int unsigned SIG_W = 32;
  localparam int unsigned NSTEP = 8;
  localparam logic [SIG_W-1:0] GEN_POLY     = 32'h8020_0003;
  localparam logic [SIG_W-1:0] GEN_FALLBACK = 32'hC0DE_5EED;

  // configuration register indices
  localparam logic [2:0] RA_SEED   = 3'd0;
  localparam logic [2:0] RA_NPAT   = 3'd1;
  localparam logic [2:0] RA_SLEN   = 3'd2;
  localparam logic [2:0] RA_DEPTH  = 3'd3;
  localparam logic [2:0] RA_STEPLO = 3'd4;
  localparam logic [2:0] RA_STEPHI = 3'd5;
  localparam logic [2:0] RA_EXPECT = 3'd6;
  localparam logic [2:0] RA_CASE   = 3'd7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEED, ST_SHIFT, ST_CAPTURE, ST_NEXT, ST_COMPARE
  } seq_state_e;

  // one Galois step, right-shifting
  function automatic logic [SIG_W-1:0] galois_step(input logic [SIG_W-1:0] s);
    return s[0] ? ((s >> 1) ^ GEN_POLY) : (s >> 1);
  endfunction

  // signature update: step, then fold the incoming response word
  function automatic logic [SIG_W-1:0] misr_fold(input logic [SIG_W-1:0] s,
                                                 input logic [SIG_W-1:0] d);
    return galois_step(s) ^ d;
  endfunction

  function automatic logic [SIG_W-1:0] seed_fix(input logic [SIG_W-1:0] s);
    return (s == '0) ? GEN_FALLBACK : s;
  endfunction

endpackage

// File: rtl/lbist_cfg_regs.sv
module lbist_cfg_regs
  import lbist_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NDOM   = 3,
  parameter int unsigned CASE_W = 8,
  localparam int unsigned DEPTH_W = $clog2(NSTEP) + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [2:0]                  wr_addr,
  input  logic [SIG_W-1:0]            wr_data,
  input  logic                        lock,
  output logic [SIG_W-1:0]            seed,
  output logic [CNT_W-1:0]            npat,
  output logic [CNT_W-1:0]            shift_len,
  output logic [DEPTH_W-1:0]          depth,
  output logic [NSTEP-1:0][NDOM-1:0]  steps,
  output logic [SIG_W-1:0]            expect_sig,
  output logic [CASE_W-1:0]           case_val
);

  localparam int unsigned HALF = NSTEP / 2;

  logic wr_ok;
  assign wr_ok = wr_en && !lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed       <= '0;
      npat       <= CNT_W'(1);
      shift_len  <= CNT_W'(1);
      depth      <= DEPTH_W'(1);
      steps      <= '0;
      expect_sig <= '0;
      case_val   <= '0;
    end else if (wr_ok) begin
      case (wr_addr)
        RA_SEED:   seed       <= wr_data;
        RA_NPAT:   npat       <= wr_data[CNT_W-1:0];
        RA_SLEN:   shift_len  <= wr_data[CNT_W-1:0];
        RA_DEPTH:  depth      <= wr_data[DEPTH_W-1:0];
        RA_STEPLO: for (int j = 0; j < HALF; j++) steps[j]        <= wr_data[8*j +: NDOM];
        RA_STEPHI: for (int j = 0; j < HALF; j++) steps[HALF + j] <= wr_data[8*j +: NDOM];
        RA_EXPECT: expect_sig <= wr_data;
        default:   case_val   <= wr_data[CASE_W-1:0];
      endcase
    end
  end

  // R10: nothing moves while a session holds the lock
  p_locked_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable({seed, npat, shift_len, depth, steps, expect_sig, case_val}));

endmodule

// File: rtl/lbist_prpg.sv
module lbist_prpg
  import lbist_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SIG_W-1:0]  seed,
  input  logic              adv,
  input  logic              drive_en,
  output logic [NCH-1:0]    scan_in,
  output logic [SIG_W-1:0]  gen_state
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gen_state <= GEN_FALLBACK;
    else if (load)   gen_state <= seed_fix(seed);
    else if (adv)    gen_state <= galois_step(gen_state);
  end

  assign scan_in = drive_en ? gen_state[NCH-1:0] : '0;

  // R2: the zero-seed substitution keeps the generator out of its lock-up state
  p_gen_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gen_state != '0);

  // R2: a load takes the substituted seed in the following cycle
  p_gen_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load && (seed != '0) |=> gen_state == $past(seed));

endmodule

// File: rtl/lbist_misr.sv
module lbist_misr
  import lbist_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              en,
  input  logic [NCH-1:0]    resp,
  input  logic [NCH-1:0]    xmask,
  output logic [SIG_W-1:0]  sig
);

  logic [NCH-1:0]   resp_clean;
  logic [SIG_W-1:0] fold_word;

  assign resp_clean = resp & ~xmask;
  assign fold_word  = {{(SIG_W-NCH){1'b0}}, resp_clean};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sig <= '0;
    else if (clear) sig <= '0;
    else if (en)    sig <= misr_fold(sig, fold_word);
  end

  // R7: a cleared signature reads zero next cycle
  p_misr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> sig == '0);

  // R8: with every bit masked the response cannot reach the signature
  p_xmask_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en && !clear && (xmask == '1) |=> sig == galois_step($past(sig)));

endmodule

// File: rtl/lbist_seq.sv
module lbist_seq
  import lbist_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned NDOM  = 3,
  localparam int unsigned IDX_W   = $clog2(NSTEP),
  localparam int unsigned DEPTH_W = IDX_W + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [CNT_W-1:0]            npat,
  input  logic [CNT_W-1:0]            shift_len,
  input  logic [DEPTH_W-1:0]          depth,
  input  logic [NSTEP-1:0][NDOM-1:0]  steps,
  output logic                        scan_en,
  output logic [NDOM-1:0]             dom_en,
  output logic                        gen_load,
  output logic                        gen_adv,
  output logic                        drive_en,
  output logic                        misr_clear,
  output logic                        misr_en,
  output logic                        done,
  output logic                        busy
);

  seq_state_e        state;
  logic [CNT_W-1:0]  pat_cnt;
  logic [CNT_W-1:0]  shift_cnt;
  logic [IDX_W-1:0]  step_idx;
  logic              unload_q;

  // named internal events
  logic [CNT_W:0]    shift_nxt;
  logic [CNT_W:0]    pat_nxt;
  logic [DEPTH_W-1:0] step_nxt;
  logic [IDX_W-1:0]  idx_nxt;
  logic              shift_last;
  logic              pat_last;
  logic              step_last;
  logic [NDOM-1:0]   cur_mask;
  logic              next_mask_zero;

  assign shift_nxt  = {1'b0, shift_cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign pat_nxt    = {1'b0, pat_cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign step_nxt   = {1'b0, step_idx} + {{IDX_W{1'b0}}, 1'b1};
  assign idx_nxt    = step_idx + IDX_W'(1);
  assign shift_last = shift_nxt >= {1'b0, shift_len};
  assign pat_last   = pat_nxt >= {1'b0, npat};
  assign cur_mask   = steps[step_idx];
  assign next_mask_zero = (step_idx == IDX_W'(NSTEP-1)) || (steps[idx_nxt] == '0);
  assign step_last  = (step_nxt >= depth) || next_mask_zero || (cur_mask == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pat_cnt   <= '0;
      shift_cnt <= '0;
      step_idx  <= '0;
      unload_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_COMPARE: if (start) state <= ST_SEED;
        ST_SEED: begin
          pat_cnt   <= '0;
          shift_cnt <= '0;
          step_idx  <= '0;
          unload_q  <= 1'b0;
          state     <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (shift_last) begin
            shift_cnt <= '0;
            step_idx  <= '0;
            state     <= unload_q ? ST_COMPARE : ST_CAPTURE;
          end else begin
            shift_cnt <= shift_nxt[CNT_W-1:0];
          end
        end
        ST_CAPTURE: begin
          if (step_last) state <= ST_NEXT;
          else           step_idx <= idx_nxt;
        end
        ST_NEXT: begin
          pat_cnt <= pat_nxt[CNT_W-1:0];
          if (pat_last) unload_q <= 1'b1;
          state <= ST_SHIFT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign scan_en    = (state == ST_SHIFT);
  assign dom_en     = (state == ST_SHIFT)   ? '1 :
                      (state == ST_CAPTURE) ? cur_mask : '0;
  assign gen_load   = (state == ST_SEED);
  assign gen_adv    = scan_en && !unload_q;
  assign drive_en   = scan_en && !unload_q;
  assign misr_clear = (state == ST_SEED);
  assign misr_en    = scan_en && (pat_cnt != '0);
  assign done       = (state == ST_COMPARE);
  assign busy       = (state != ST_IDLE) && (state != ST_COMPARE);

  // R6: shifting clocks every domain
  p_shift_all_dom_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> dom_en == '1);

  // R3: shift counter never passes the programmed length
  p_shift_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en && (shift_len != '0) |-> shift_cnt < shift_len);

  // R5: capture index stays inside the programmed depth
  p_cap_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CAPTURE) && (depth != '0) |-> {1'b0, step_idx} < depth);

  // R9: completion holds until a new start
  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  // R7: the first pass never compacts
  p_first_pass_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gen_load |=> !misr_en);

endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
  import lbist_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned NDOM   = 3,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned CASE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              start,
  output logic              done,
  output logic              pass,
  output logic [NDOM-1:0]   dom_clk_en,
  output logic              scan_en,
  output logic [NCH-1:0]    scan_in,
  input  logic [NCH-1:0]    scan_out,
  input  logic [NCH-1:0]    xmask,
  output logic [CASE_W-1:0] case_ctl
);

  localparam int unsigned DEPTH_W = $clog2(NSTEP) + 1;

  logic [SIG_W-1:0]           seed_w, expect_w, sig_w, gen_w;
  logic [CNT_W-1:0]           npat_w, slen_w;
  logic [DEPTH_W-1:0]         depth_w;
  logic [NSTEP-1:0][NDOM-1:0] steps_w;
  logic                       busy_w, load_w, adv_w, drive_w, clr_w, men_w;
  logic                       sig_match;

  lbist_cfg_regs #(.CNT_W(CNT_W), .NDOM(NDOM), .CASE_W(CASE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .lock(busy_w), .seed(seed_w), .npat(npat_w),
    .shift_len(slen_w), .depth(depth_w), .steps(steps_w),
    .expect_sig(expect_w), .case_val(case_ctl)
  );

  lbist_seq #(.CNT_W(CNT_W), .NDOM(NDOM)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .npat(npat_w),
    .shift_len(slen_w), .depth(depth_w), .steps(steps_w),
    .scan_en(scan_en), .dom_en(dom_clk_en), .gen_load(load_w),
    .gen_adv(adv_w), .drive_en(drive_w), .misr_clear(clr_w),
    .misr_en(men_w), .done(done), .busy(busy_w)
  );

  lbist_prpg #(.NCH(NCH)) u_prpg (
    .clk(clk), .rst_n(rst_n), .load(load_w), .seed(seed_w), .adv(adv_w),
    .drive_en(drive_w), .scan_in(scan_in), .gen_state(gen_w)
  );

  lbist_misr #(.NCH(NCH)) u_misr (
    .clk(clk), .rst_n(rst_n), .clear(clr_w), .en(men_w),
    .resp(scan_out), .xmask(xmask), .sig(sig_w)
  );

  assign sig_match = (sig_w == expect_w);
  assign pass      = done && sig_match;

  // R9: pass only ever accompanies done
  p_pass_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);

  // R9: the signature is frozen while the result is shown
  p_sig_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> $stable(sig_w));

  // R11: the unload pass does not touch the generator
  p_unload_gen_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en && !drive_w |=> $stable(gen_w));

endmodule

// File: tb/test_lbist_ctrl.sv
module test_lbist_ctrl;

  localparam int NCH = 4;
  localparam int NDOM = 3;
  localparam int CASE_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [2:0]        cfg_addr = '0;
  logic [31:0]       cfg_wdata = '0;
  logic              start = 1'b0;
  logic              done, pass, scan_en;
  logic [NDOM-1:0]   dom_clk_en;
  logic [NCH-1:0]    scan_in, scan_out, xmask;
  logic [CASE_W-1:0] case_ctl;

  lbist_ctrl i_lbist_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .start(start), .done(done), .pass(pass),
    .dom_clk_en(dom_clk_en), .scan_en(scan_en), .scan_in(scan_in),
    .scan_out(scan_out), .xmask(xmask), .case_ctl(case_ctl)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // ---- scan chain stand-in ----
  logic [63:0] chain [NCH];
  int          sh_cnt = 0;
  bit          clr = 1'b0;
  bit          xm_en = 1'b0;
  int          cur_len = 1;
  int          cur_pat = 1;
  logic [5:0]  lidx;

  function automatic logic [63:0] cap_fn(input logic [63:0] v);
    return v ^ (v << 1) ^ 64'h1;
  endfunction

  function automatic bit xm_fn(input int n, input int c);
    return xm_en && (((n * 7 + c * 3) % 5) == 0);
  endfunction

  function automatic bit junk_fn(input int n, input int c);
    return ((n * 13 + c * 11 + 5) % 3) != 0;
  endfunction

  always @(posedge clk) begin
    if (clr) begin
      for (int c = 0; c < NCH; c++) chain[c] <= '0;
      sh_cnt <= 0;
    end else if (scan_en) begin
      for (int c = 0; c < NCH; c++) chain[c] <= {chain[c][62:0], scan_in[c]};
      sh_cnt <= sh_cnt + 1;
    end else begin
      for (int c = 0; c < NCH; c++)
        if (dom_clk_en[c % NDOM]) chain[c] <= cap_fn(chain[c]);
    end
  end

  always_comb begin
    lidx = 6'(cur_len - 1);
    for (int c = 0; c < NCH; c++) begin
      xmask[c]    = xm_fn(sh_cnt, c);
      scan_out[c] = chain[c][lidx] ^ (xmask[c] & junk_fn(sh_cnt, c));
    end
  end

  // ---- monitors ----
  int              mon_shift, mon_viol6, mon_viol11, mon_log_n;
  int              mon_cap [NDOM];
  logic [NDOM-1:0] mon_log [8];
  logic [NCH-1:0]  mon_first;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (scan_en) begin
        mon_shift++;
        if (dom_clk_en != '1) mon_viol6++;
        if (sh_cnt == 0) mon_first = scan_in;
        if (sh_cnt >= cur_pat * cur_len && scan_in != '0) mon_viol11++;
      end else if (dom_clk_en != '0) begin
        for (int d = 0; d < NDOM; d++) if (dom_clk_en[d]) mon_cap[d]++;
        if (sh_cnt == cur_len && mon_log_n < 8) begin
          mon_log[mon_log_n] = dom_clk_en;
          mon_log_n++;
        end
      end
    end
  end

  // ---- bench arithmetic, written independently ----
  function automatic logic [31:0] tb_step(input logic [31:0] s);
    logic [31:0] n;
    n = {s[0], s[31:1]};
    n[21] = s[22] ^ s[0];
    n[1]  = s[2] ^ s[0];
    n[0]  = s[1] ^ s[0];
    return n;
  endfunction

  logic [31:0]     exp_sig;
  int              exp_cap [NDOM];
  logic [NDOM-1:0] exp_log [8];
  int              exp_log_n;

  task automatic model(input logic [31:0] seed, input int p_n, input int l_n,
                       input int d_n, input logic [7:0][7:0] st);
    logic [31:0]    lf, sg, word;
    logic [63:0]    ch [NCH];
    logic [NCH-1:0] outv, xmv;
    int             n;
    lf = (seed == 0) ? 32'hC0DE5EED : seed;
    sg = '0;
    n  = 0;
    exp_log_n = 0;
    for (int d = 0; d < NDOM; d++) exp_cap[d] = 0;
    for (int c = 0; c < NCH; c++) ch[c] = '0;
    for (int p = 0; p <= p_n; p++) begin
      for (int k = 0; k < l_n; k++) begin
        for (int c = 0; c < NCH; c++) begin
          outv[c] = ch[c][l_n-1];
          xmv[c]  = xm_fn(n, c);
          ch[c]   = {ch[c][62:0], (p < p_n) ? lf[c] : 1'b0};
        end
        word = {28'd0, outv & ~xmv};
        if (p > 0) sg = tb_step(sg) ^ word;
        if (p < p_n) lf = tb_step(lf);
        n++;
      end
      if (p < p_n) begin
        for (int i = 0; i < d_n; i++) begin
          if (st[i][NDOM-1:0] == '0) break;
          for (int c = 0; c < NCH; c++)
            if (st[i][c % NDOM]) ch[c] = cap_fn(ch[c]);
          for (int dd = 0; dd < NDOM; dd++) if (st[i][dd]) exp_cap[dd]++;
          if (p == 0) begin
            exp_log[exp_log_n] = st[i][NDOM-1:0];
            exp_log_n++;
          end
        end
      end
    end
    exp_sig = sg;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(negedge clk) if (cyc > 150000) begin
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
    finish_run();
  end

  task automatic run(input logic [31:0] seed, input int npat, input int len,
                     input int depth, input logic [7:0][7:0] st,
                     input bit corrupt, input bit xon, input bit mid_wr);
    int p_e, l_e, d_e, w;
    logic [CASE_W-1:0] case_before;
    logic [31:0] first_exp;
    p_e = (npat == 0) ? 1 : npat;
    l_e = (len == 0) ? 1 : len;
    d_e = (depth == 0) ? 1 : ((depth > 8) ? 8 : depth);
    wr(3'd0, seed);
    wr(3'd1, 32'(npat));
    wr(3'd2, 32'(len));
    wr(3'd3, 32'(depth));
    wr(3'd4, st[3:0]);
    wr(3'd5, st[7:4]);
    xm_en = xon;
    model(seed, p_e, l_e, d_e, st);
    wr(3'd6, corrupt ? (exp_sig ^ 32'h1) : exp_sig);
    @(negedge clk);
    cur_len = l_e; cur_pat = p_e; clr = 1'b1;
    mon_shift = 0; mon_viol6 = 0; mon_viol11 = 0; mon_log_n = 0;
    for (int d = 0; d < NDOM; d++) mon_cap[d] = 0;
    @(negedge clk);
    clr = 1'b0;
    case_before = case_ctl;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (!done && w < 20000) begin
      @(negedge clk);
      if (mid_wr && w == 2) begin
        cfg_we = 1'b1; cfg_addr = 3'd7; cfg_wdata = 32'(~case_before);
      end
      if (w == 3) cfg_we = 1'b0;
      w++;
    end
    cfg_we = 1'b0;
    chk(done == 1'b1, "R9", "done reached", 32'(done), 32'd1);
    chk(pass == !corrupt, xon ? "R8" : "R7", "pass vs model signature",
        32'(pass), 32'(!corrupt));
    chk(mon_shift == (p_e + 1) * l_e, "R4", "shift cycles (R3 length)",
        32'(mon_shift), 32'((p_e + 1) * l_e));
    for (int d = 0; d < NDOM; d++)
      chk(mon_cap[d] == exp_cap[d], "R5", "capture pulses per domain",
          32'(mon_cap[d]), 32'(exp_cap[d]));
    chk(mon_log_n == exp_log_n, "R5", "capture step count", 32'(mon_log_n),
        32'(exp_log_n));
    for (int i = 0; i < exp_log_n && i < mon_log_n; i++)
      chk(mon_log[i] == exp_log[i], "R5", "capture step order",
          32'(mon_log[i]), 32'(exp_log[i]));
    chk(mon_viol6 == 0, "R6", "shift without all domains", 32'(mon_viol6), 32'd0);
    chk(mon_viol11 == 0, "R11", "nonzero drive in unload pass",
        32'(mon_viol11), 32'd0);
    first_exp = (seed == 0) ? 32'hC0DE5EED : seed;
    chk(mon_first == first_exp[NCH-1:0], "R2", "first stimulus",
        32'(mon_first), 32'(first_exp[NCH-1:0]));
    chk(case_ctl == case_before, "R10", "case held during session",
        32'(case_ctl), 32'(case_before));
    repeat (3) @(negedge clk);
    chk(done && (pass == !corrupt), "R9", "result held", {30'd0, done, pass},
        {30'd0, 1'b1, !corrupt});
    chk(scan_en == 1'b0 && dom_clk_en == '0, "R6", "quiet while done",
        {28'd0, scan_en, dom_clk_en}, 32'd0);
  endtask

  initial begin
    logic [7:0][7:0] st;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && pass == 1'b0, "R1", "done/pass at reset",
        {30'd0, done, pass}, 32'd0);
    chk(scan_en == 1'b0, "R1", "scan_en at reset", 32'(scan_en), 32'd0);
    chk(dom_clk_en == '0, "R1", "dom_clk_en at reset", 32'(dom_clk_en), 32'd0);
    chk(case_ctl == '0, "R1", "case_ctl at reset", 32'(case_ctl), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    wr(3'd7, 32'h5A);
    chk(case_ctl == 8'h5A, "R10", "case write when idle", 32'(case_ctl), 32'h5A);

    // directed corners
    st = {8'd0, 8'd0, 8'd0, 8'd0, 8'd3, 8'd4, 8'd2, 8'd1};
    run(32'h1234_5678, 3, 5, 4, st, 1'b0, 1'b0, 1'b1);      // R5 ordered steps, R10 mid write
    run(32'h0, 2, 4, 8, st, 1'b0, 1'b0, 1'b0);              // R2 zero seed
    st = {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0};
    run(32'hDEAD_BEEF, 0, 0, 3, st, 1'b0, 1'b0, 1'b0);      // R3 len 0, R4 npat 0, R5 zero first step
    st = {8'd1, 8'd2, 8'd4, 8'd3, 8'd5, 8'd6, 8'd7, 8'd1};
    run(32'hA5A5_0F0F, 4, 7, 15, st, 1'b0, 1'b1, 1'b0);     // R5 depth past 8, R8 X masked
    run(32'hA5A5_0F0F, 4, 7, 15, st, 1'b1, 1'b1, 1'b0);     // R9 mismatch
    st = {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd2, 8'd0, 8'd7};
    run(32'h0BAD_F00D, 2, 3, 6, st, 1'b0, 1'b1, 1'b0);      // R5 stops at zero mid-table

    for (int i = 0; i < 16; i++) begin
      for (int s = 0; s < 8; s++) st[s] = 8'($urandom % 8);
      run($urandom, int'($urandom % 6) + 1, int'($urandom % 12) + 1,
          int'($urandom % 10), st, (i % 3) == 2, ($urandom % 2) == 1, (i % 4) == 0);
    end

    wr(3'd7, 32'hC3);
    chk(case_ctl == 8'hC3, "R10", "case write when done", 32'(case_ctl), 32'hC3);
    finish_run();
  end

endmodule